// File: doc/BRIEF.md
# Nybble-Serial Strobed Link Transmitter

This block moves one byte from a sending processor to a receiving processor over four data lines and a single strobe line. The byte is split into its two 4-bit halves. The upper half goes first and is announced by a rising strobe edge. The lower half follows and is announced by the falling edge. After each byte the strobe is therefore back at its low rest level. Each half is driven onto the lines a fixed setup time before the strobe edge that marks it, and the two edges of one byte are a fixed gap apart. Both times are parameters counted in clock cycles. The defaults, 9 and 30, suit a 1 MHz clock.

A request is accepted only while the transmitter is idle. A request that arrives while a byte is in flight is dropped. A one-cycle completion pulse marks the falling edge, and the busy flag then clears one cycle later. The control is a five-state machine:
- `ST_IDLE`: lines at zero, strobe low. It moves to `ST_LEAD_HI` on a request.
- `ST_LEAD_HI`: upper half on the lines, strobe low, for `SETUP_CYC` cycles. It then moves to `ST_HOLD_HI`.
- `ST_HOLD_HI`: strobe high, upper half held, for `GAP_CYC-SETUP_CYC` cycles. It then moves to `ST_LEAD_LO`.
- `ST_LEAD_LO`: strobe high, lower half on the lines, for `SETUP_CYC` cycles. It then moves to `ST_DONE`.
- `ST_DONE`: strobe low, lower half held, done high, for one cycle. It then returns to `ST_IDLE`.

The parameters must satisfy `GAP_CYC > SETUP_CYC >= 1`.

Top module: `nyb_link_tx`

## Requirements
- R1: After reset, the strobe is low, the data lines are 0, and both busy and done are low.
- R2: A request sampled on a clock edge while busy is low is accepted. From that edge on, busy is high and the lines carry bits [7:4] of the request byte.
- R3: The strobe rises exactly `SETUP_CYC` cycles after the accepting edge. The upper half stays on the lines throughout those cycles.
- R4: The strobe falls exactly `GAP_CYC` cycles after it rose.
- R5: The lines switch to bits [3:0] of the accepted byte exactly `GAP_CYC` cycles after the accepting edge, which is `SETUP_CYC` cycles before the falling edge.
- R6: The lines do not change in the cycle of either strobe edge. A receiver that captures the lines on the rising edge as the upper half, and on the falling edge as the lower half, rebuilds the accepted byte.
- R7: Done is high for exactly the one cycle that begins with the falling strobe edge. Busy goes low at the following edge.
- R8: A request made while busy is high, including during the done cycle, is ignored. The byte in flight and its timing are unchanged, and no extra transfer follows.
- R9: While busy is low, the strobe is low and the lines are 0. A request presented in the first idle cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| send_req | input | 1 | Request to send `send_byte` |
| send_byte | input | 8 | Byte to transmit |
| link_nyb | output | 4 | Nybble data lines |
| link_stb | output | 1 | Strobe, rests low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on the falling strobe edge |

## Verification
Let k be the edge that accepts a request, and count offsets from it. Busy and the upper half are due at k. The rising edge is due at k+`SETUP_CYC`. The lower half is due at k+`GAP_CYC`. The falling edge and done are due at k+`SETUP_CYC`+`GAP_CYC`. Busy clears one edge after that. The bench drives and samples only on falling clock edges. It compares the full set of outputs with a schedule computed from these offsets on every cycle from k to the first idle cycle. A model receiver, triggered by the strobe edges, rebuilds each byte, which is then compared with the byte that was sent. Stray requests are injected at random offsets inside a transfer, and the per-cycle comparison shows they disturb nothing.

// File: rtl/nyb_link_pkg.sv
package nyb_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LEAD_HI = 3'd1,
        ST_HOLD_HI = 3'd2,
        ST_LEAD_LO = 3'd3,
        ST_DONE    = 3'd4
    } tx_state_t;

    typedef enum logic [1:0] {
        HALF_NONE = 2'd0,
        HALF_UPPER = 2'd1,
        HALF_LOWER = 2'd2
    } half_sel_t;

endpackage

// File: rtl/nyb_phase_timer.sv
module nyb_phase_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final cycle of the current phase.
    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/nyb_half_sel.sv
module nyb_half_sel
    import nyb_link_pkg::*;
#(
    parameter int NYB_W = 4,
    localparam int WORD_W = 2 * NYB_W
) (
    input  logic [WORD_W-1:0] word,
    input  half_sel_t         sel,
    output logic [NYB_W-1:0]  nyb
);

    always_comb begin
        unique case (sel)
            HALF_UPPER: nyb = word[WORD_W-1:NYB_W];
            HALF_LOWER: nyb = word[NYB_W-1:0];
            default:    nyb = '0;
        endcase
    end

endmodule

// File: rtl/nyb_link_tx.sv
module nyb_link_tx
    import nyb_link_pkg::*;
#(
    parameter int NYB_W     = 4,
    parameter int SETUP_CYC = 9,
    parameter int GAP_CYC   = 30,
    localparam int WORD_W   = 2 * NYB_W,
    localparam int CNT_W    = $clog2(GAP_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    input  logic [WORD_W-1:0] send_byte,
    output logic [NYB_W-1:0]  link_nyb,
    output logic              link_stb,
    output logic              busy,
    output logic              done
);

    localparam logic [CNT_W-1:0] LEN_SETUP = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] LEN_HOLD  = CNT_W'(GAP_CYC - SETUP_CYC);

    tx_state_t         state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic              phase_last;
    logic              phase_load;
    logic [CNT_W-1:0]  phase_len;
    half_sel_t         half;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (send_req)   state_d = ST_LEAD_HI;
            ST_LEAD_HI: if (phase_last) state_d = ST_HOLD_HI;
            ST_HOLD_HI: if (phase_last) state_d = ST_LEAD_LO;
            ST_LEAD_LO: if (phase_last) state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        phase_load = (state_d != state_q);
        unique case (state_d)
            ST_HOLD_HI: phase_len = LEN_HOLD;
            ST_LEAD_HI,
            ST_LEAD_LO: phase_len = LEN_SETUP;
            default:    phase_len = '0;
        endcase
    end

    // State register and captured word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && send_req) begin
                word_q <= send_byte;
            end
        end
    end

    nyb_phase_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_len (phase_len),
        .last     (phase_last)
    );

    // Outputs decoded from state
    always_comb begin
        unique case (state_q)
            ST_LEAD_HI: begin half = HALF_UPPER; link_stb = 1'b0; busy = 1'b1; done = 1'b0; end
            ST_HOLD_HI: begin half = HALF_UPPER; link_stb = 1'b1; busy = 1'b1; done = 1'b0; end
            ST_LEAD_LO: begin half = HALF_LOWER; link_stb = 1'b1; busy = 1'b1; done = 1'b0; end
            ST_DONE:    begin half = HALF_LOWER; link_stb = 1'b0; busy = 1'b1; done = 1'b1; end
            default:    begin half = HALF_NONE;  link_stb = 1'b0; busy = 1'b0; done = 1'b0; end
        endcase
    end

    nyb_half_sel #(
        .NYB_W (NYB_W)
    ) i_sel (
        .word (word_q),
        .sel  (half),
        .nyb  (link_nyb)
    );

endmodule

// File: rtl/nyb_link_tx_chk.sv
module nyb_link_tx_chk #(
    parameter int NYB_W     = 4,
    parameter int SETUP_CYC = 9,
    parameter int GAP_CYC   = 30,
    localparam int WORD_W   = 2 * NYB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              send_req,
    input logic [WORD_W-1:0] send_byte,
    input logic [NYB_W-1:0]  link_nyb,
    input logic              link_stb,
    input logic              busy,
    input logic              done
);

    // Cycles since the accepting edge
    logic [15:0] since_acc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_acc <= '0;
        else if (!busy)             since_acc <= '0;
        else if (since_acc != '1)   since_acc <= since_acc + 1'b1;
    end

    p_idle_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!link_stb && link_nyb == '0));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && !busy) |=> (busy && link_nyb == $past(send_byte[WORD_W-1:NYB_W])));

    p_rise_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_stb) |-> (since_acc == 16'(SETUP_CYC)));

    p_fall_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_stb) |-> (since_acc == 16'(SETUP_CYC + GAP_CYC)));

    p_edge_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_stb) || $fell(link_stb)) |-> $stable(link_nyb));

    p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(link_stb));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && send_req) |=> busy);

endmodule

bind nyb_link_tx nyb_link_tx_chk #(
    .NYB_W     (NYB_W),
    .SETUP_CYC (SETUP_CYC),
    .GAP_CYC   (GAP_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .send_req  (send_req),
    .send_byte (send_byte),
    .link_nyb  (link_nyb),
    .link_stb  (link_stb),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_nyb_link_tx.sv
module test_nyb_link_tx;

    localparam int CLK_PERIOD = 10;
    localparam int SETUP = 9;
    localparam int GAP   = 30;
    localparam int SPAN  = SETUP + GAP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send_req = 1'b0;
    logic [7:0] send_byte = 8'h00;
    logic [3:0] link_nyb;
    logic       link_stb;
    logic       busy;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nyb_link_tx #(
        .NYB_W     (4),
        .SETUP_CYC (SETUP),
        .GAP_CYC   (GAP)
    ) i_nyb_link_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_req  (send_req),
        .send_byte (send_byte),
        .link_nyb  (link_nyb),
        .link_stb  (link_stb),
        .busy      (busy),
        .done      (done)
    );

    // Model receiver
    logic [7:0] rx_byte = 8'h00;
    always @(posedge link_stb) rx_byte[7:4] = link_nyb;
    always @(negedge link_stb) rx_byte[3:0] = link_nyb;

    // Expected {stb, nyb, busy, done} at offset j after the accepting edge
    function automatic logic [6:0] exp_at(input int j, input logic [7:0] b);
        logic       stb;
        logic [3:0] nyb;
        logic       bz;
        logic       dn;
        stb = (j >= SETUP) && (j < SPAN);
        bz  = (j <= SPAN);
        dn  = (j == SPAN);
        nyb = !bz ? 4'h0 : (j < GAP ? b[7:4] : b[3:0]);
        return {stb, nyb, bz, dn};
    endfunction

    function automatic string tag_at(input int j);
        if (j == 0)          return "R2";
        if (j < SETUP)       return "R3";
        if (j == SETUP)      return "R6";
        if (j < GAP)         return "R4";
        if (j == GAP)        return "R5";
        if (j < SPAN)        return "R5";
        if (j == SPAN)       return "R7";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Send b; optionally inject a stray request at offset junk_at (-1 none).
    task automatic send(input logic [7:0] b, input int junk_at);
        logic [7:0] junk;
        junk = 8'($urandom);
        send_req  = 1'b1;
        send_byte = b;
        @(posedge clk);
        @(negedge clk);
        send_req  = 1'b0;
        send_byte = 8'($urandom);
        for (int j = 0; j <= SPAN + 1; j++) begin
            check(tag_at(j), {25'd0, link_stb, link_nyb, busy, done}, {25'd0, exp_at(j, b)});
            send_req = (j == junk_at);
            if (j == junk_at) send_byte = junk;
            if (j <= SPAN) @(negedge clk);
        end
        send_req = 1'b0;
        check(junk_at >= 0 ? "R8" : "R6", {24'd0, rx_byte}, {24'd0, b});
    endtask

    initial begin
        void'($urandom(32'd2024));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R1: reset state
        check("R1", {28'd0, link_stb, busy, done, |link_nyb}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {28'd0, link_stb, busy, done, |link_nyb}, 32'd0);

        // Directed corners
        send(8'hA5, -1);
        send(8'h00, -1);           // back to back, zero upper half (R9)
        send(8'hFF, 0);            // stray request right after accept (R8)
        send(8'h3C, SPAN);         // stray request during done cycle (R8)
        check("R9", {31'd0, busy}, 32'd0);
        send(8'h96, SETUP - 1);    // stray request just before rise (R8)

        // Random traffic
        for (int n = 0; n < 40; n++) begin
            int gap;
            int jat;
            gap = int'($urandom_range(0, 4));
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check("R9", {27'd0, link_stb, link_nyb}, 32'd0);
            end
            jat = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, SPAN)) : -1;
            send(8'($urandom), jat);
        end

        // No extra transfer after last byte (R8)
        repeat (SPAN + 4) begin
            @(negedge clk);
            check("R8", {30'd0, busy, link_stb}, 32'd0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule